// File: doc/BRIEF.md
# Dual-Bank Accumulator Register File

This block holds the working registers of an 8-bit accumulator-style processor core: the accumulator and flag byte, three general register pairs, a complete second (shadow) copy of those eight bytes, and two index registers. One write port and two combinational read ports reach the registers. Each access names either a single byte register or a register pair, and the same 4-bit selector field is used for both kinds of access. A mode input picks whether pairs are 16 or 24 bits wide. In 24-bit mode the three general pairs (in both banks) and both index registers carry an upper extension byte. That byte can only be reached through a pair access.

Two exchange strobes swap the active and shadow copies. One swaps only the accumulator/flag pair. The other swaps the three general pairs together, including their extension bytes. Each swap takes one cycle and moves no data: it flips a bank-select bit, and there is one such bit per swap group. The instruction decoder drives the selectors and strobes. The ALU consumes the read data.

Top module: `shadow_regbank`

## Requirements
- R1: After reset, every register byte and every extension byte reads as zero, and bank 0 is active for both swap groups.
- R2: Byte codes select registers as follows: 0 accumulator, 1 flags, 2..7 the general bytes in the order B C D E H L, 8 IX low, 9 IX high, 10 IY low, 11 IY high. A byte write on the rising edge takes bits [BYTE_W-1:0] of the write data and is visible on the combinational byte read in the following cycle.
- R3: Pair codes are 0 AF, 1 BC, 2 DE, 3 HL, 4 IX and 5 IY. A pair read returns the first-named byte in bits [2*BYTE_W-1:BYTE_W] and the second-named byte in the low byte. In 16-bit mode the top byte of the pair read is zero.
- R4: Byte codes 12..15 and pair codes 6..15 read as zero, and writes to them change no register.
- R5: In 24-bit mode, a pair write to BC, DE, HL, IX or IY stores the top byte of the write data into that pair's extension byte, and a pair read returns it. The AF pair has no extension, so its top byte always reads zero.
- R6: A pair write in 16-bit mode leaves that pair's extension byte unchanged.
- R7: The AF swap strobe exchanges the active AF pair with its shadow and leaves BC, DE, HL, IX and IY untouched.
- R8: The general swap strobe exchanges BC, DE and HL, including their extension bytes, with their shadows in one cycle. It leaves AF, IX and IY untouched.
- R9: A write in the same cycle as a swap lands in the bank that was active before the swap. Both strobes together swap both groups.
- R10: Byte writes never alter an extension byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 24-bit pairs, 0 selects 16-bit pairs |
| wr_en | input | 1 | Write strobe |
| wr_is_pair | input | 1 | 1 means wr_sel is a pair code, 0 a byte code |
| wr_sel | input | 4 | Register or pair code for the write |
| wr_data | input | 3*BYTE_W | Write data, low byte first |
| swap_af | input | 1 | Exchange the AF pair with its shadow |
| swap_main | input | 1 | Exchange BC, DE and HL with their shadows |
| rd_byte_sel | input | 4 | Byte code for the byte read |
| rd_byte_data | output | BYTE_W | Selected byte, combinational |
| rd_pair_sel | input | 4 | Pair code for the pair read |
| rd_pair_data | output | 3*BYTE_W | Selected pair, combinational |

## Verification
Reads are combinational, so a read result is due in the same cycle its selector is applied. A write or swap is due one rising edge after the strobe. The bench drives every strobe on a falling edge and drops it on the next falling edge, by which point exactly one rising edge has passed. It then sweeps all sixteen byte codes and all sixteen pair codes in both width modes against a bench-side model of the two banks. Swaps, same-cycle write-and-swap, narrow writes into wide pairs and a long pseudo-random mix are each followed by such a full sweep.

// File: rtl/srb_pkg.sv
package srb_pkg;
   localparam int SEL_W     = 4;
   localparam int BANK_REGS = 8;   // A F B C D E H L
   localparam int BANK_EXTS = 3;   // upper bytes of BC DE HL
   localparam int IDX_REGS  = 2;   // IX IY
   localparam int BANKS     = 2;

   localparam logic [SEL_W-1:0] BYTE_IDX_BASE = 4'd8;
   localparam logic [SEL_W-1:0] BYTE_LAST     = 4'd11;
   localparam logic [SEL_W-1:0] PAIR_AF       = 4'd0;
   localparam logic [SEL_W-1:0] PAIR_IDX_BASE = 4'd4;
   localparam logic [SEL_W-1:0] PAIR_LAST     = 4'd5;
endpackage

// File: rtl/srb_regstore.sv
module srb_regstore #(
   parameter int BYTE_W = 8,
   parameter int NREG   = 8,
   parameter int NEXT   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG-1:0]             byte_we,
   input  logic [NREG-1:0][BYTE_W-1:0] byte_wd,
   input  logic [NEXT-1:0]             ext_we,
   input  logic [BYTE_W-1:0]           ext_wd,
   output logic [NREG-1:0][BYTE_W-1:0] byte_q,
   output logic [NEXT-1:0][BYTE_W-1:0] ext_q
);
   if (BYTE_W < 2) begin : g_bad_width
      $error("srb_regstore: BYTE_W must be at least 2");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          byte_q[i] <= '0;
         else if (byte_we[i]) byte_q[i] <= byte_wd[i];
      end
   end

   for (genvar j = 0; j < NEXT; j++) begin : g_ext
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ext_q[j] <= '0;
         else if (ext_we[j]) ext_q[j] <= ext_wd;
      end
   end
endmodule

// File: rtl/srb_wrdecode.sv
module srb_wrdecode
   import srb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                                   wr_en,
   input  logic                                   wr_is_pair,
   input  logic [SEL_W-1:0]                       wr_sel,
   input  logic [3*BYTE_W-1:0]                    wr_data,
   input  logic                                   wide_mode,
   input  logic                                   af_sel,
   input  logic                                   main_sel,
   output logic [BANKS-1:0][BANK_REGS-1:0]        bank_byte_we,
   output logic [BANK_REGS-1:0][BYTE_W-1:0]       bank_byte_wd,
   output logic [BANKS-1:0][BANK_EXTS-1:0]        bank_ext_we,
   output logic [IDX_REGS-1:0][1:0]               idx_byte_we,
   output logic [1:0][BYTE_W-1:0]                 idx_byte_wd,
   output logic [IDX_REGS-1:0]                    idx_ext_we,
   output logic [BYTE_W-1:0]                      ext_wd
);
   logic [BYTE_W-1:0] lo_byte, hi_byte, up_byte;
   logic              byte_wr, pair_wr;

   assign lo_byte = wr_data[BYTE_W-1:0];
   assign hi_byte = wr_data[2*BYTE_W-1:BYTE_W];
   assign up_byte = wr_data[3*BYTE_W-1:2*BYTE_W];
   assign byte_wr = wr_en && !wr_is_pair;
   assign pair_wr = wr_en &&  wr_is_pair;
   assign ext_wd  = up_byte;

   // banked bytes: pair p covers byte codes 2p (high) and 2p+1 (low)
   for (genvar i = 0; i < BANK_REGS; i++) begin : g_bank_byte
      logic hit, owner;
      assign hit   = (byte_wr && wr_sel == SEL_W'(i)) ||
                     (pair_wr && wr_sel == SEL_W'(i / 2));
      assign owner = (i < 2) ? af_sel : main_sel;
      assign bank_byte_wd[i] = (wr_is_pair && (i % 2 == 0)) ? hi_byte : lo_byte;
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         assign bank_byte_we[b][i] = hit && (owner == 1'(b));
      end
   end

   for (genvar j = 0; j < BANK_EXTS; j++) begin : g_bank_ext
      logic hit;
      assign hit = pair_wr && wide_mode && wr_sel == SEL_W'(j + 1);
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         assign bank_ext_we[b][j] = hit && (main_sel == 1'(b));
      end
   end

   // index registers: halves 0 = low, 1 = high
   assign idx_byte_wd[0] = lo_byte;
   assign idx_byte_wd[1] = wr_is_pair ? hi_byte : lo_byte;

   for (genvar k = 0; k < IDX_REGS; k++) begin : g_idx
      logic pair_hit;
      assign pair_hit = pair_wr && wr_sel == (PAIR_IDX_BASE + SEL_W'(k));
      for (genvar h = 0; h < 2; h++) begin : g_half
         assign idx_byte_we[k][h] = pair_hit ||
            (byte_wr && wr_sel == (BYTE_IDX_BASE + SEL_W'(2 * k + h)));
      end
      assign idx_ext_we[k] = pair_hit && wide_mode;
   end
endmodule

// File: rtl/srb_rdmux.sv
module srb_rdmux
   import srb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BANKS-1:0][BANK_REGS-1:0][BYTE_W-1:0] bank_byte,
   input  logic [BANKS-1:0][BANK_EXTS-1:0][BYTE_W-1:0] bank_ext,
   input  logic [IDX_REGS-1:0][1:0][BYTE_W-1:0]        idx_byte,
   input  logic [IDX_REGS-1:0][BYTE_W-1:0]             idx_ext,
   input  logic                                        af_sel,
   input  logic                                        main_sel,
   input  logic                                        wide_mode,
   input  logic [SEL_W-1:0]                            rd_byte_sel,
   output logic [BYTE_W-1:0]                           rd_byte_data,
   input  logic [SEL_W-1:0]                            rd_pair_sel,
   output logic [3*BYTE_W-1:0]                         rd_pair_data
);
   logic [BANK_REGS-1:0][BYTE_W-1:0] act_byte;
   logic [BANK_EXTS-1:0][BYTE_W-1:0] act_ext;

   for (genvar i = 0; i < BANK_REGS; i++) begin : g_act
      if (i < 2) begin : g_af
         assign act_byte[i] = bank_byte[af_sel][i];
      end else begin : g_main
         assign act_byte[i] = bank_byte[main_sel][i];
      end
   end
   assign act_ext = bank_ext[main_sel];

   always_comb begin
      rd_byte_data = '0;
      if (rd_byte_sel < BYTE_IDX_BASE)
         rd_byte_data = act_byte[rd_byte_sel[2:0]];
      else if (rd_byte_sel <= BYTE_LAST)
         rd_byte_data = idx_byte[rd_byte_sel[1]][rd_byte_sel[0]];
   end

   always_comb begin
      rd_pair_data = '0;
      if (rd_pair_sel < PAIR_IDX_BASE) begin
         rd_pair_data[2*BYTE_W-1:BYTE_W] = act_byte[{rd_pair_sel[1:0], 1'b0}];
         rd_pair_data[BYTE_W-1:0]        = act_byte[{rd_pair_sel[1:0], 1'b1}];
         if (wide_mode && rd_pair_sel != PAIR_AF)
            rd_pair_data[3*BYTE_W-1:2*BYTE_W] = act_ext[rd_pair_sel[1:0] - 2'd1];
      end else if (rd_pair_sel <= PAIR_LAST) begin
         rd_pair_data[2*BYTE_W-1:BYTE_W] = idx_byte[rd_pair_sel[0]][1];
         rd_pair_data[BYTE_W-1:0]        = idx_byte[rd_pair_sel[0]][0];
         if (wide_mode)
            rd_pair_data[3*BYTE_W-1:2*BYTE_W] = idx_ext[rd_pair_sel[0]];
      end
   end
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
   import srb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide_mode,
   input  logic                wr_en,
   input  logic                wr_is_pair,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [3*BYTE_W-1:0] wr_data,
   input  logic                swap_af,
   input  logic                swap_main,
   input  logic [SEL_W-1:0]    rd_byte_sel,
   output logic [BYTE_W-1:0]   rd_byte_data,
   input  logic [SEL_W-1:0]    rd_pair_sel,
   output logic [3*BYTE_W-1:0] rd_pair_data
);
   localparam int PAIR_W = 3 * BYTE_W;

   if (BYTE_W < 2 || BYTE_W > 32) begin : g_bad_width
      $error("shadow_regbank: BYTE_W out of range");
   end
   if (PAIR_W != 3 * BYTE_W) begin : g_bad_pair
      $error("shadow_regbank: pair width mismatch");
   end

   logic af_sel_q, main_sel_q;

   logic [BANKS-1:0][BANK_REGS-1:0]              bank_byte_we;
   logic [BANK_REGS-1:0][BYTE_W-1:0]             bank_byte_wd;
   logic [BANKS-1:0][BANK_EXTS-1:0]              bank_ext_we;
   logic [BANKS-1:0][BANK_REGS-1:0][BYTE_W-1:0]  bank_byte;
   logic [BANKS-1:0][BANK_EXTS-1:0][BYTE_W-1:0]  bank_ext;
   logic [IDX_REGS-1:0][1:0]                     idx_byte_we;
   logic [1:0][BYTE_W-1:0]                       idx_byte_wd;
   logic [IDX_REGS-1:0]                          idx_ext_we;
   logic [IDX_REGS-1:0][1:0][BYTE_W-1:0]         idx_byte;
   logic [IDX_REGS-1:0][BYTE_W-1:0]              idx_ext;
   logic [BYTE_W-1:0]                            ext_wd;

   // bank pointers: a swap only flips the pointer of its group
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         af_sel_q   <= 1'b0;
         main_sel_q <= 1'b0;
      end else begin
         if (swap_af)   af_sel_q   <= ~af_sel_q;
         if (swap_main) main_sel_q <= ~main_sel_q;
      end
   end

   srb_wrdecode #(.BYTE_W(BYTE_W)) u_dec (
      .wr_en        (wr_en),
      .wr_is_pair   (wr_is_pair),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .wide_mode    (wide_mode),
      .af_sel       (af_sel_q),
      .main_sel     (main_sel_q),
      .bank_byte_we (bank_byte_we),
      .bank_byte_wd (bank_byte_wd),
      .bank_ext_we  (bank_ext_we),
      .idx_byte_we  (idx_byte_we),
      .idx_byte_wd  (idx_byte_wd),
      .idx_ext_we   (idx_ext_we),
      .ext_wd       (ext_wd)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      srb_regstore #(.BYTE_W(BYTE_W), .NREG(BANK_REGS), .NEXT(BANK_EXTS)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .byte_we (bank_byte_we[b]),
         .byte_wd (bank_byte_wd),
         .ext_we  (bank_ext_we[b]),
         .ext_wd  (ext_wd),
         .byte_q  (bank_byte[b]),
         .ext_q   (bank_ext[b])
      );
   end

   for (genvar k = 0; k < IDX_REGS; k++) begin : g_idx
      logic [0:0][BYTE_W-1:0] ext_one;
      srb_regstore #(.BYTE_W(BYTE_W), .NREG(2), .NEXT(1)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .byte_we (idx_byte_we[k]),
         .byte_wd (idx_byte_wd),
         .ext_we  (idx_ext_we[k]),
         .ext_wd  (ext_wd),
         .byte_q  (idx_byte[k]),
         .ext_q   (ext_one)
      );
      assign idx_ext[k] = ext_one[0];
   end

   srb_rdmux #(.BYTE_W(BYTE_W)) u_rd (
      .bank_byte    (bank_byte),
      .bank_ext     (bank_ext),
      .idx_byte     (idx_byte),
      .idx_ext      (idx_ext),
      .af_sel       (af_sel_q),
      .main_sel     (main_sel_q),
      .wide_mode    (wide_mode),
      .rd_byte_sel  (rd_byte_sel),
      .rd_byte_data (rd_byte_data),
      .rd_pair_sel  (rd_pair_sel),
      .rd_pair_data (rd_pair_data)
   );
endmodule

// File: rtl/shadow_regbank_checker.sv
module shadow_regbank_checker
   import srb_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int EXT_W  = 8 * BYTE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wide_mode,
   input logic                wr_en,
   input logic                wr_is_pair,
   input logic                swap_af,
   input logic                swap_main,
   input logic                af_sel_q,
   input logic                main_sel_q,
   input logic [EXT_W-1:0]    all_ext,
   input logic [SEL_W-1:0]    rd_byte_sel,
   input logic [BYTE_W-1:0]   rd_byte_data,
   input logic [SEL_W-1:0]    rd_pair_sel,
   input logic [3*BYTE_W-1:0] rd_pair_data
);
   // R7: AF strobe flips the AF bank pointer, otherwise it holds
   a_r7_af_flip: assert property (@(posedge clk) disable iff (!rst_n)
      swap_af |=> (af_sel_q != $past(af_sel_q)));
   a_r7_af_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_af |=> $stable(af_sel_q));
   // R8: general strobe flips the general bank pointer, otherwise it holds
   a_r8_main_flip: assert property (@(posedge clk) disable iff (!rst_n)
      swap_main |=> (main_sel_q != $past(main_sel_q)));
   a_r8_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_main |=> $stable(main_sel_q));
   // R6: no extension byte moves while in 16-bit mode
   a_r6_narrow_keeps_ext: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |=> $stable(all_ext));
   // R10: byte writes never move an extension byte
   a_r10_byte_wr_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_is_pair) |=> $stable(all_ext));
   // R3: top byte of a pair read is zero in 16-bit mode
   a_r3_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> (rd_pair_data[3*BYTE_W-1:2*BYTE_W] == '0));
   // R4: unused codes read as zero
   a_r4_byte_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte_sel > BYTE_LAST) |-> (rd_byte_data == '0));
   a_r4_pair_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pair_sel > PAIR_LAST) |-> (rd_pair_data == '0));
   // R5: AF never carries an upper byte
   a_r5_af_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pair_sel == PAIR_AF) |-> (rd_pair_data[3*BYTE_W-1:2*BYTE_W] == '0));
endmodule

bind shadow_regbank shadow_regbank_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wide_mode    (wide_mode),
   .wr_en        (wr_en),
   .wr_is_pair   (wr_is_pair),
   .swap_af      (swap_af),
   .swap_main    (swap_main),
   .af_sel_q     (af_sel_q),
   .main_sel_q   (main_sel_q),
   .all_ext      ({bank_ext, idx_ext}),
   .rd_byte_sel  (rd_byte_sel),
   .rd_byte_data (rd_byte_data),
   .rd_pair_sel  (rd_pair_sel),
   .rd_pair_data (rd_pair_data)
);

// File: tb/shadow_regbank_bench.sv
module shadow_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_is_pair = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [23:0] wr_data = '0;
   logic        swap_af = 1'b0;
   logic        swap_main = 1'b0;
   logic [3:0]  rd_byte_sel = '0;
   logic [7:0]  rd_byte_data;
   logic [3:0]  rd_pair_sel = '0;
   logic [23:0] rd_pair_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   shadow_regbank u_shadow_regbank (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
      .wr_en(wr_en), .wr_is_pair(wr_is_pair), .wr_sel(wr_sel), .wr_data(wr_data),
      .swap_af(swap_af), .swap_main(swap_main),
      .rd_byte_sel(rd_byte_sel), .rd_byte_data(rd_byte_data),
      .rd_pair_sel(rd_pair_sel), .rd_pair_data(rd_pair_data)
   );

   // model: mb[bank][code] for codes 0..7, me[bank][pair-1], ib[index][half], ie[index]
   logic [7:0] mb [2][8];
   logic [7:0] me [2][3];
   logic [7:0] ib [2][2];
   logic [7:0] ie [2];
   int         m_af = 0;
   int         m_gen = 0;

   task automatic model_clear();
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 8; i++) mb[b][i] = 8'h00;
         for (int j = 0; j < 3; j++) me[b][j] = 8'h00;
         ib[b][0] = 8'h00; ib[b][1] = 8'h00; ie[b] = 8'h00;
      end
      m_af = 0; m_gen = 0;
   endtask

   function automatic logic [7:0] exp_byte(int c);
      if (c < 2)  return mb[m_af][c];
      if (c < 8)  return mb[m_gen][c];
      if (c < 12) return ib[(c - 8) / 2][(c - 8) % 2];
      return 8'h00;
   endfunction

   function automatic logic [23:0] exp_pair(int p, bit w);
      if (p == 0) return {8'h00, mb[m_af][0], mb[m_af][1]};
      if (p < 4)  return {(w ? me[m_gen][p-1] : 8'h00), mb[m_gen][2*p], mb[m_gen][2*p+1]};
      if (p < 6)  return {(w ? ie[p-4] : 8'h00), ib[p-4][1], ib[p-4][0]};
      return 24'h0;
   endfunction

   task automatic model_write(bit pr, int s, logic [23:0] d, bit w);
      if (!pr) begin
         if (s < 2)       mb[m_af][s] = d[7:0];
         else if (s < 8)  mb[m_gen][s] = d[7:0];
         else if (s < 12) ib[(s-8)/2][(s-8)%2] = d[7:0];
      end else begin
         if (s == 0) begin
            mb[m_af][0] = d[15:8]; mb[m_af][1] = d[7:0];
         end else if (s < 4) begin
            mb[m_gen][2*s] = d[15:8]; mb[m_gen][2*s+1] = d[7:0];
            if (w) me[m_gen][s-1] = d[23:16];
         end else if (s < 6) begin
            ib[s-4][1] = d[15:8]; ib[s-4][0] = d[7:0];
            if (w) ie[s-4] = d[23:16];
         end
      end
   endtask

   task automatic check(string req, string what, logic [23:0] act, logic [23:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clocked operation: drive on a falling edge, one rising edge passes
   task automatic op(bit we, bit pr, int s, logic [23:0] d, bit w, bit sa, bit sm);
      @(negedge clk);
      wide_mode = w; wr_en = we; wr_is_pair = pr; wr_sel = 4'(s); wr_data = d;
      swap_af = sa; swap_main = sm;
      if (we) model_write(pr, s, d, w);
      if (sa) m_af = 1 - m_af;
      if (sm) m_gen = 1 - m_gen;
      @(negedge clk);
      wr_en = 1'b0; swap_af = 1'b0; swap_main = 1'b0;
   endtask

   // full sweep of both read ports, both widths; reads are combinational
   task automatic sweep(string ctx);
      bit keep;
      keep = wide_mode;
      for (int c = 0; c < 16; c++) begin
         rd_byte_sel = 4'(c);
         #1;
         check(c < 12 ? "R2" : "R4", $sformatf("%s byte code %0d", ctx, c),
               {16'h0, rd_byte_data}, {16'h0, exp_byte(c)});
      end
      for (int w = 0; w < 2; w++) begin
         wide_mode = w[0];
         for (int p = 0; p < 16; p++) begin
            rd_pair_sel = 4'(p);
            #1;
            check(p > 5 ? "R4" : (w == 1 ? "R5" : "R3"),
                  $sformatf("%s pair code %0d wide %0d", ctx, p, w),
                  rd_pair_data, exp_pair(p, w[0]));
         end
      end
      wide_mode = keep;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 reset");

      // R2 / R4: every byte code, then every pair code narrow and wide
      for (int c = 0; c < 16; c++) op(1, 0, c, 24'hC3_5A00 | 24'((c * 37 + 5) & 8'hFF), 0, 0, 0);
      sweep("R2 byte writes");
      for (int p = 0; p < 16; p++) op(1, 1, p, 24'(32'h10_2030 + p * 32'h0B_0D11), 1, 0, 0);
      sweep("R5 wide pair writes");

      // R6: narrow pair writes keep extensions
      for (int p = 1; p < 6; p++) op(1, 1, p, 24'(32'hEE_0000 + p * 32'h0101), 0, 0, 0);
      sweep("R6 narrow pair writes");

      // R10: byte writes to B..L and index halves keep extensions
      for (int c = 2; c < 12; c++) op(1, 0, c, 24'hFF_FF00 | 24'(c), 1, 0, 0);
      sweep("R10 byte writes");

      // R7: AF swap, fill the shadow AF, swap back
      op(0, 0, 0, 24'h0, 1, 1, 0);
      sweep("R7 af swapped");
      op(1, 1, 0, 24'h00_9876, 1, 0, 0);
      op(0, 0, 0, 24'h0, 1, 1, 0);
      sweep("R7 af restored");

      // R8: general swap, fill shadow pairs with extensions
      op(0, 0, 0, 24'h0, 1, 0, 1);
      sweep("R8 general swapped");
      for (int p = 1; p < 4; p++) op(1, 1, p, 24'(32'h40_0000 + p * 32'h11_1111), 1, 0, 0);
      op(0, 0, 0, 24'h0, 1, 0, 1);
      sweep("R8 general restored");

      // R9: write in the swap cycle lands in the old bank
      op(1, 0, 2, 24'h0000_A5, 1, 0, 1);
      sweep("R9 byte write with general swap");
      op(1, 1, 0, 24'h00_BEEF, 1, 1, 0);
      sweep("R9 pair write with af swap");
      op(1, 1, 3, 24'h77_6655, 1, 1, 1);
      sweep("R9 both swaps with write");
      op(0, 0, 0, 24'h0, 1, 1, 1);
      sweep("R9 both swaps back");

      // mixed pseudo-random traffic
      seed = 32'h1234_5678;
      for (int it = 0; it < 300; it++) begin
         int r;
         seed = seed * 1103515245 + 12345;
         r = (seed >>> 8) & 32'h7FFF_FFFF;
         op(r[0] | r[1], r[2], int'(r[6:3]), r[30:7], r[11], r[12] & r[13], r[14] & r[15]);
         if (it % 10 == 9) sweep("R9 mixed traffic");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule